// File: doc/BRIEF.md
# Microinstruction Phase Timing and Step Controller

This block produces the phase strobes that sequence a microprogrammed processor. Each microinstruction is cut into numbered phases, T1 to T5 by default. A microinstruction can also end early at T3, and the phase after the last one is always T1 again. The phases can advance on every cycle of the main clock, on each rising edge of a slower maintenance clock, or under a manual step pushbutton.

Two maintenance switches pick the operating mode. With the step-enable switch at 0 the sequencer runs freely. A third select input then chooses between the main clock and the maintenance clock. With the step-enable switch at 1, the phase switch chooses what one press does: a whole microinstruction when the phase switch is 0, a single phase when it is 1.

Every selection input passes through flip-flops clocked by the main clock. A new selection takes effect only at a microinstruction boundary. A power-fail input stops and clears the sequencer and asks the microsequencer to load the reset entry address.

Top module: `tg_phase_ctrl`

## Requirements
- R1: While reset is applied and just after it, no phase strobe, boundary pulse or address-force is asserted. The first strobe after reset is T1.
- R2: With the step-enable switch and the slow select both at 0, strobes T1, T2, T3, T4, T5 come out on consecutive main clock cycles and then repeat. Only one strobe is ever active at a time. `uinst_done` pulses together with the last strobe of each microinstruction. Strobe bit k (LSB = T1) is phase T(k+1).
- R3: When `short_cycle` is 1, the microinstruction ends after T3 and the next strobe is T1. `uinst_done` pulses with that T3.
- R4: With the step-enable switch at 0 and the slow select at 1, each rising edge of `maint_clk` advances exactly one phase. Without such edges there are no strobes.
- R5: With the step-enable switch at 1 and the phase switch at 0, each button press runs exactly one whole microinstruction, T1 up to its last phase.
- R6: With the step-enable switch at 1 and the phase switch at 1, each button press produces exactly one strobe, the next phase in order.
- R7: While the step-enable switch is 0, button presses produce no strobes. Clearing that switch drops the manual-step enable at once.
- R8: A change of the selected mode takes effect only at a microinstruction boundary. If phase stepping is left part-way through an instruction, the remaining phases are issued on the main clock before the new mode applies.
- R9: While `pwr_fail` is high, no strobes are issued, `uaddr_force` is 1 and `uaddr_init` is octal 200. After release, the first strobe is T1.
- R10: A press held for many cycles counts as a single press, because the button is synchronized and edge-detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_fail | input | 1 | Power-fail/ROM-init request; clears the sequencer |
| sw_step_en | input | 1 | Maintenance switch: 1 enables manual stepping |
| sw_phase | input | 1 | Maintenance switch: 1 steps by phase, 0 by microinstruction |
| slow_sel | input | 1 | Free-run source: 1 maintenance clock, 0 main clock |
| maint_clk | input | 1 | Slow maintenance clock, sampled by the main clock |
| step_btn | input | 1 | Manual step pushbutton |
| short_cycle | input | 1 | Current microinstruction ends at T3 |
| phase_stb | output | NPH | One-hot phase strobes, bit 0 = T1 |
| uinst_done | output | 1 | Pulse with the last phase of a microinstruction |
| uaddr_force | output | 1 | Request to load the reset microaddress |
| uaddr_init | output | UAW | Reset microaddress, valid while uaddr_force is 1 |

## Verification
The bench builds the block with its defaults: five phases, a short end at T3, two synchronizer stages and a 9-bit microaddress with reset entry octal 200. With five phases, the long and short cycles give clearly different wrap points in the recorded strobe history. Two synchronizer stages keep the latency from press to strobe short, so several button presses fit into a short window. The bench also leaves phase stepping part-way through an instruction and asserts power-fail during free run, which exercises the boundary rule and the restart at T1.

// File: rtl/tg_pkg.sv
package tg_pkg;
   typedef enum logic [1:0] {
      M_RUN_MAIN   = 2'd0,
      M_RUN_SLOW   = 2'd1,
      M_STEP_UINST = 2'd2,
      M_STEP_PHASE = 2'd3
   } tg_mode_e;

   function automatic tg_mode_e tg_decode(input logic step_en, input logic by_phase,
                                          input logic slow);
      if (step_en) return by_phase ? M_STEP_PHASE : M_STEP_UINST;
      return slow ? M_RUN_SLOW : M_RUN_MAIN;
   endfunction
endpackage

// File: rtl/tg_sync.sv
module tg_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2,
   parameter bit EDGE   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] rise
);
   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

   generate
      if (EDGE) begin : g_edge
         logic [WIDTH-1:0] prev;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev <= '0;
            else        prev <= q;
         end
         assign rise = q & ~prev;
      end else begin : g_level
         assign rise = '0;
      end
   endgenerate
endmodule

// File: rtl/tg_src_sel.sv
module tg_src_sel
   import tg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_fail,
   input  logic s_step_en,
   input  logic s_phase,
   input  logic s_slow,
   input  logic slow_rise,
   input  logic press,
   input  logic ph_zero,
   input  logic at_last,
   output logic tick
);
   tg_mode_e mode_q, mode_eff;
   logic     mstep_en, en_eff, armed;

   // a new selection only applies while the sequencer sits at T1
   assign mode_eff = ph_zero ? tg_decode(s_step_en, s_phase, s_slow) : mode_q;
   assign en_eff   = s_step_en && (mstep_en || ph_zero);

   always_comb begin
      tick = 1'b0;
      unique case (mode_eff)
         M_RUN_MAIN:   tick = 1'b1;
         M_RUN_SLOW:   tick = slow_rise;
         M_STEP_UINST: tick = armed;
         M_STEP_PHASE: tick = (press && en_eff) || (!en_eff && !ph_zero);
         default:      tick = 1'b0;
      endcase
      if (pwr_fail) tick = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= M_RUN_MAIN;
         mstep_en <= 1'b0;
         armed    <= 1'b0;
      end else begin
         mode_q   <= mode_eff;
         mstep_en <= en_eff;
         if (pwr_fail)
            armed <= 1'b0;
         else if (armed && tick && at_last)
            armed <= 1'b0;
         else if (!armed && press && en_eff && mode_eff == M_STEP_UINST)
            armed <= 1'b1;
      end
   end

   // R8: the registered mode moves only across a boundary
   a_r8_mode_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode_q) |-> $past(ph_zero));
   // R7: removing the step-enable switch drops the enable next cycle
   a_r7_enable_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !s_step_en |=> !mstep_en);
endmodule

// File: rtl/tg_phase_seq.sv
module tg_phase_seq #(
   parameter int NPH        = 5,
   parameter int SHORT_LAST = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pwr_fail,
   input  logic           tick,
   input  logic           short_cycle,
   output logic [NPH-1:0] phase_stb,
   output logic           uinst_done,
   output logic           ph_zero,
   output logic           at_last
);
   localparam int PW = $clog2(NPH);
   localparam logic [PW-1:0] LAST_LONG  = PW'(NPH - 1);
   localparam logic [PW-1:0] LAST_SHORT = PW'(SHORT_LAST - 1);

   logic [PW-1:0] ph;

   assign ph_zero = (ph == '0);
   assign at_last = (ph == LAST_LONG) || (short_cycle && ph == LAST_SHORT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph         <= '0;
         phase_stb  <= '0;
         uinst_done <= 1'b0;
      end else if (pwr_fail) begin
         ph         <= '0;
         phase_stb  <= '0;
         uinst_done <= 1'b0;
      end else begin
         phase_stb  <= tick ? (NPH'(1) << ph) : '0;
         uinst_done <= tick && at_last;
         if (tick) ph <= at_last ? '0 : ph + PW'(1);
      end
   end

   // R2: never two phases at once
   a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(phase_stb));
   // R2: a finished microinstruction leaves the sequencer at T1
   a_r2_done_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      uinst_done |-> ph_zero);
   // R3: the boundary pulse goes only with a possible last phase
   a_r3_done_with_last: assert property (@(posedge clk) disable iff (!rst_n)
      uinst_done |-> (phase_stb[NPH-1] || phase_stb[SHORT_LAST-1]));
   // R9: power-fail silences the strobes
   a_r9_pwr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |=> (phase_stb == '0));
endmodule

// File: rtl/tg_phase_ctrl.sv
module tg_phase_ctrl #(
   parameter int NPH         = 5,
   parameter int SHORT_LAST  = 3,
   parameter int SYNC_STAGES = 2,
   parameter int UAW         = 9,
   parameter logic [UAW-1:0] UADDR_RESET = UAW'(9'o200)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pwr_fail,
   input  logic           sw_step_en,
   input  logic           sw_phase,
   input  logic           slow_sel,
   input  logic           maint_clk,
   input  logic           step_btn,
   input  logic           short_cycle,
   output logic [NPH-1:0] phase_stb,
   output logic           uinst_done,
   output logic           uaddr_force,
   output logic [UAW-1:0] uaddr_init
);
   generate
      if (NPH < 3 || NPH > 16) begin : g_bad_nph
         $error("NPH out of range");
      end
      if (SHORT_LAST < 1 || SHORT_LAST >= NPH) begin : g_bad_short
         $error("SHORT_LAST must lie below NPH");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [2:0] sw_q, sw_unused;
   logic [1:0] ev_q, ev_rise;
   logic       tick, ph_zero, at_last;

   tg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .EDGE(1'b0)) i_sw_sync (
      .clk(clk), .rst_n(rst_n), .d({sw_step_en, sw_phase, slow_sel}),
      .q(sw_q), .rise(sw_unused));

   tg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .EDGE(1'b1)) i_ev_sync (
      .clk(clk), .rst_n(rst_n), .d({maint_clk, step_btn}),
      .q(ev_q), .rise(ev_rise));

   tg_src_sel i_src (
      .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail),
      .s_step_en(sw_q[2]), .s_phase(sw_q[1]), .s_slow(sw_q[0]),
      .slow_rise(ev_rise[1]), .press(ev_rise[0]),
      .ph_zero(ph_zero), .at_last(at_last), .tick(tick));

   tg_phase_seq #(.NPH(NPH), .SHORT_LAST(SHORT_LAST)) i_seq (
      .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .tick(tick),
      .short_cycle(short_cycle), .phase_stb(phase_stb),
      .uinst_done(uinst_done), .ph_zero(ph_zero), .at_last(at_last));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) uaddr_force <= 1'b0;
      else        uaddr_force <= pwr_fail;
   end

   assign uaddr_init = uaddr_force ? UADDR_RESET : '0;

   // R9: the force request follows a power-fail
   a_r9_force_follows: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |=> (uaddr_force && uaddr_init == UADDR_RESET));
endmodule

// File: tb/test_tg_phase_ctrl.sv
module test_tg_phase_ctrl;
   localparam int NPH = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_fail = 1'b0, sw_step_en = 1'b0, sw_phase = 1'b0, slow_sel = 1'b0;
   logic maint_clk = 1'b0, step_btn = 1'b0, short_cycle = 1'b0;
   logic [NPH-1:0] phase_stb;
   logic uinst_done, uaddr_force;
   logic [8:0] uaddr_init;

   always #2.5 clk = ~clk;

   tg_phase_ctrl i_tg_phase_ctrl (
      .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .sw_step_en(sw_step_en),
      .sw_phase(sw_phase), .slow_sel(slow_sel), .maint_clk(maint_clk),
      .step_btn(step_btn), .short_cycle(short_cycle), .phase_stb(phase_stb),
      .uinst_done(uinst_done), .uaddr_force(uaddr_force), .uaddr_init(uaddr_init));

   // strobe history recorded away from the active edge
   logic [3:0] hist [2048];
   int tot = 0, dn_tot = 0;
   always @(negedge clk) begin
      for (int k = 0; k < NPH; k++)
         if (phase_stb[k] && tot < 2048) begin
            hist[tot] = 4'(k + 1);
            tot = tot + 1;
         end
      if (uinst_done) dn_tot = dn_tot + 1;
   end

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic chk_seq(input int c0, input logic [63:0] exp, input int n, input string what);
      logic [63:0] act = '0;
      int got = tot - c0;
      for (int i = 0; i < got && i < 16; i++) act = {act[59:0], hist[c0 + i]};
      chk(got == n && act == exp, what, act, exp);
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic press(input int hold);
      @(negedge clk) step_btn = 1'b1;
      cyc(hold);
      step_btn = 1'b0;
      cyc(8);
   endtask

   typedef struct packed {
      logic [1:0]  sw;     // {step_en, phase}
      logic        slow;
      logic        t3;
      logic [1:0]  act;    // 1 = maint clock edges, 2 = presses
      logic [7:0]  n;
      logic [63:0] exp;
      logic [7:0]  cnt;
      logic [7:0]  dn;
   } vec_t;

   localparam vec_t TBL [8] = '{
      '{2'b00, 1'b1, 1'b0, 2'd1, 8'd10, 64'h1234512345, 8'd10, 8'd2}, // R4 slow source
      '{2'b00, 1'b1, 1'b1, 2'd1, 8'd6,  64'h123123,     8'd6,  8'd2}, // R3 short cycle
      '{2'b00, 1'b1, 1'b0, 2'd2, 8'd3,  64'h0,          8'd0,  8'd0}, // R7 press ignored
      '{2'b10, 1'b1, 1'b0, 2'd2, 8'd2,  64'h1234512345, 8'd10, 8'd2}, // R5 uinst step
      '{2'b10, 1'b1, 1'b1, 2'd2, 8'd1,  64'h123,        8'd3,  8'd1}, // R5 with R3
      '{2'b11, 1'b1, 1'b0, 2'd2, 8'd3,  64'h123,        8'd3,  8'd0}, // R6 phase step
      '{2'b11, 1'b1, 1'b0, 2'd2, 8'd2,  64'h45,         8'd2,  8'd1}, // R6 continues
      '{2'b11, 1'b1, 1'b1, 2'd2, 8'd3,  64'h123,        8'd3,  8'd1}  // R6 with R3
   };

   initial begin
      int c0, d0;
      // R1 reset state
      cyc(4);
      chk(phase_stb == '0, "R1 strobes in reset", phase_stb, 0);
      chk(uinst_done == 1'b0 && uaddr_force == 1'b0, "R1 done/force in reset",
          {uinst_done, uaddr_force}, 0);
      rst_n = 1'b1;
      cyc(30);
      // R2 main free run, R1 first strobe is T1
      chk(hist[0] == 4'd1, "R1 first strobe", hist[0], 1);
      begin
         logic [63:0] a = '0;
         for (int i = 0; i < 10; i++) a = {a[59:0], hist[i]};
         chk(a == 64'h1234512345, "R2 free-run order", a, 64'h1234512345);
      end
      chk(dn_tot >= 5, "R2 boundary pulses", dn_tot, 5);
      slow_sel = 1'b1;
      cyc(20);
      // R9 power-fail during main free run
      slow_sel = 1'b0;
      cyc(9);
      pwr_fail = 1'b1;
      cyc(2);
      chk(uaddr_force == 1'b1 && uaddr_init == 9'o200, "R9 force address",
          uaddr_init, 9'o200);
      c0 = tot;
      cyc(10);
      chk(tot == c0 && phase_stb == '0, "R9 sequencer stopped", tot - c0, 0);
      pwr_fail = 1'b0;
      cyc(5);
      chk(tot > c0 && hist[c0] == 4'd1, "R9 restart at T1", hist[c0], 1);
      chk(uaddr_force == 1'b0, "R9 force released", uaddr_force, 0);
      slow_sel = 1'b1;
      cyc(20);

      // table of modes
      for (int v = 0; v < 8; v++) begin
         {sw_step_en, sw_phase} = TBL[v].sw;
         slow_sel = TBL[v].slow;
         short_cycle = TBL[v].t3;
         cyc(12);
         c0 = tot; d0 = dn_tot;
         for (int j = 0; j < int'(TBL[v].n); j++) begin
            if (TBL[v].act == 2'd1) begin
               maint_clk = 1'b1; cyc(4); maint_clk = 1'b0; cyc(4);
            end else begin
               press(6);
            end
         end
         cyc(12);
         chk_seq(c0, TBL[v].exp, int'(TBL[v].cnt), $sformatf("table vector %0d strobes", v));
         chk(dn_tot - d0 == int'(TBL[v].dn), $sformatf("table vector %0d boundaries", v),
             dn_tot - d0, TBL[v].dn);
      end

      // R8 leaving phase stepping mid-instruction
      short_cycle = 1'b0;
      cyc(5);
      c0 = tot; d0 = dn_tot;
      press(6); press(6);
      sw_step_en = 1'b0; sw_phase = 1'b0;
      cyc(20);
      chk_seq(c0, 64'h12345, 5, "R8 flush to boundary");
      chk(dn_tot - d0 == 1, "R8 one boundary", dn_tot - d0, 1);
      c0 = tot;
      press(6);
      cyc(6);
      chk(tot == c0, "R7 press after enable dropped", tot - c0, 0);

      // R10 long press counts once
      sw_step_en = 1'b1; sw_phase = 1'b1;
      cyc(12);
      c0 = tot;
      press(40);
      cyc(6);
      chk_seq(c0, 64'h1, 1, "R10 long press single step");

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule